// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that an attached storage device and its host controller can both run, never going above a mode the caller asks for. The caller presents the device's identify words, the host capability masks, the cable type, the media type and the requested mode code, and pulses a strobe. One clock later the block presents the chosen mode code, or zero when DMA cannot be used, along with a flag that marks an inconsistent identify block. A done pulse comes with the outputs.

Mode codes are formed as a family base plus a mode index. Single-word DMA uses base 0x10, multiword DMA uses base 0x20 and Ultra DMA uses base 0x40, so Ultra DMA mode 5 is 0x45. The code 0x00 means no DMA. Families are tried from fastest to slowest. Within a family, the highest mode that both sides allow is taken. A cable that is not 80-wire limits the Ultra DMA choice. A single-word fallback taken from a legacy timing field covers devices that do not report the newer mode words.

Top module: `xfer_mode_select`

## Requirements
- R1: Reset sets the mode output, the error flag and done to 0. A strobe on `req_valid` at one rising edge produces `sel_mode`, `id_error` and a one-cycle `done` at the next edge. Without a strobe, `sel_mode` and `id_error` hold their values and `done` stays 0.
- R2: When `is_disk` is 0 and `host_no_atapi_dma` is 1, the selected mode is 0x00. Either flag on its own has no effect.
- R3: Families are tried in the order Ultra DMA (base 0x40), multiword (base 0x20), single-word (base 0x10). A family whose base is above `req_mode` is skipped. The first family that remains and has a non-zero mask wins. A request below 0x10 gives 0x00.
- R4: Within the winning family, the code is the base plus the index of the highest set mask bit.
- R5: The Ultra DMA mask is `host_udma_mask & id_udma_word[7:0]`. It is used only when bit 2 of `id_valid_word` is 1.
- R6: When `req_mode` is above 0x42, `cable_80w` is 0 and the Ultra DMA mask has any of bits 6:3 set, the mask is cut to bits 2:0. A mask that has only bit 7 set is not cut.
- R7: The multiword mask is `host_mw_mask & id_mw_word[2:0]`. It is used only when bit 1 of `id_valid_word` is 1.
- R8: When bit 1 of `id_valid_word` is 1, the single-word mask is `host_sw_mask & id_sw_word[2:0]`. Otherwise a `legacy_dma_mode` of 1 or 2 gives the mask `((2 << legacy_dma_mode) - 1) & host_sw_mask`, and any other value gives an empty mask.
- R9: The output is the smaller of the chosen code and `req_mode`.
- R10: `id_error` is 1 in two cases. The first is when bit 2 of `id_valid_word` is set and the upper bytes of both the Ultra DMA word and the multiword word are non-zero. The second is when bit 2 is clear, bit 1 is set, and the upper bytes of both the multiword word and the single-word word are non-zero. In all other cases it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Strobe that starts a selection |
| req_mode | input | 8 | Highest mode code the caller allows |
| id_valid_word | input | 16 | Identify field-valid word (bit 2: Ultra DMA word valid, bit 1: DMA words valid) |
| id_udma_word | input | 16 | Identify Ultra DMA word (low byte supported, high byte active) |
| id_mw_word | input | 16 | Identify multiword DMA word |
| id_sw_word | input | 16 | Identify single-word DMA word |
| legacy_dma_mode | input | 8 | Legacy single-word DMA timing mode |
| host_udma_mask | input | 8 | Host Ultra DMA modes supported |
| host_mw_mask | input | 3 | Host multiword DMA modes supported |
| host_sw_mask | input | 3 | Host single-word DMA modes supported |
| cable_80w | input | 1 | 1 when an 80-wire cable is fitted |
| is_disk | input | 1 | 1 when the device is a disk, 0 for a packet device |
| host_no_atapi_dma | input | 1 | Host forbids DMA to packet devices |
| sel_mode | output | 8 | Selected mode code, 0x00 for no DMA |
| id_error | output | 1 | Identify mode words are inconsistent |
| done | output | 1 | One-cycle pulse when the outputs update |

## Verification
The hardest case to reach is the cable cap. It depends on three inputs at once: a request above Ultra DMA mode 2, a narrow cable, and a mask containing a middle Ultra DMA bit. The bench builds each combination by hand and pairs it with a near miss. In the near miss, only bit 7 of the Ultra DMA mask is set, so the cap must leave the fast mode in place. The legacy single-word path is also hard to reach. It is active only when the device reports no valid DMA words, so the bench clears the field-valid word and sweeps the legacy value across 0, 1, 2 and 3, using host masks that separate the resulting codes.

// File: rtl/xfer_mode_pkg.sv
`timescale 1ns/1ps
// Package: shared mode-code constants and family indexing for the selector.
// Assumes three families ordered fastest first; index 0 has highest priority.
package xfer_mode_pkg;
    localparam int MODE_W = 8;
    localparam int NFAM   = 3;
    localparam int FAM_W  = 8;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t BASE_UDMA = 8'h40;
    localparam mode_t BASE_MW   = 8'h20;
    localparam mode_t BASE_SW   = 8'h10;
    localparam mode_t MODE_NONE = 8'h00;

    typedef enum logic [1:0] {
        FAM_UDMA = 2'd0,
        FAM_MW   = 2'd1,
        FAM_SW   = 2'd2
    } fam_e;

    // Base code of a family, by priority index.
    function automatic mode_t fam_base(input int idx);
        case (idx)
            0:       return BASE_UDMA;
            1:       return BASE_MW;
            default: return BASE_SW;
        endcase
    endfunction
endpackage

// File: rtl/msb_index.sv
`timescale 1ns/1ps
// Module: reports whether a vector has any bit set and the index of the
// highest set bit. Assumes W >= 2.
module msb_index #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan upward so the last set bit seen is the highest one.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/family_mask_calc.sv
`timescale 1ns/1ps
// Module: builds the allowed-mode mask of each DMA family from the device
// words and host masks. Applies the narrow-cable cap to Ultra DMA and the
// legacy single-word fallback. Assumes UDMA_W, MW_W and SW_W are no wider
// than FAM_W and that CAP_KEEP < UDMA_W.
module family_mask_calc
    import xfer_mode_pkg::*;
#(
    parameter int UDMA_W   = 8,
    parameter int MW_W     = 3,
    parameter int SW_W     = 3,
    parameter int LEG_W    = 8,
    parameter int CAP_KEEP = 3
) (
    input  logic                        udma_ok,
    input  logic                        dma_ok,
    input  logic [UDMA_W-1:0]           udma_bits,
    input  logic [MW_W-1:0]             mw_bits,
    input  logic [SW_W-1:0]             sw_bits,
    input  logic [LEG_W-1:0]            legacy_mode,
    input  logic [UDMA_W-1:0]           host_udma,
    input  logic [MW_W-1:0]             host_mw,
    input  logic [SW_W-1:0]             host_sw,
    input  logic                        cable_80w,
    input  mode_t                       req_mode,
    output logic [NFAM-1:0][FAM_W-1:0]  fam_mask
);
    localparam logic [UDMA_W-1:0] KEEP_MASK = UDMA_W'((1 << CAP_KEEP) - 1);
    localparam logic [UDMA_W-1:0] MID_MASK  =
        UDMA_W'((1 << (UDMA_W - 1)) - 1) & ~KEEP_MASK;
    localparam mode_t CAP_REQ_LIMIT = BASE_UDMA + mode_t'(CAP_KEEP - 1);
    localparam int    LEG_MAX       = SW_W - 1;

    logic [UDMA_W-1:0] udma_raw, udma_cut;
    logic [MW_W-1:0]   mw_mask;
    logic [SW_W-1:0]   sw_mask, legacy_mask;
    logic              legacy_ok, cap_hit;

    // Ultra DMA mask: device and host agreement, then the narrow-cable cap.
    always_comb begin
        udma_raw = udma_ok ? (host_udma & udma_bits) : '0;
        cap_hit  = (req_mode > CAP_REQ_LIMIT) && ((udma_raw & MID_MASK) != '0)
                   && !cable_80w;
        udma_cut = cap_hit ? (udma_raw & KEEP_MASK) : udma_raw;
    end

    // Multiword mask: valid only with the DMA words flagged as valid.
    always_comb begin
        mw_mask = dma_ok ? (host_mw & mw_bits) : '0;
    end

    // Single-word mask: word when valid, else legacy timing fallback.
    always_comb begin
        legacy_ok   = (legacy_mode != '0) && (legacy_mode <= LEG_W'(LEG_MAX));
        legacy_mask = SW_W'((32'd2 << legacy_mode) - 32'd1);
        if (dma_ok)
            sw_mask = host_sw & sw_bits;
        else if (legacy_ok)
            sw_mask = legacy_mask & host_sw;
        else
            sw_mask = '0;
    end

    // Pack the family masks in priority order.
    always_comb begin
        fam_mask           = '0;
        fam_mask[FAM_UDMA] = FAM_W'(udma_cut);
        fam_mask[FAM_MW]   = FAM_W'(mw_mask);
        fam_mask[FAM_SW]   = FAM_W'(sw_mask);
    end
endmodule

// File: rtl/identify_check.sv
`timescale 1ns/1ps
// Module: flags identify blocks whose active-mode bytes claim two DMA
// families at once. Assumes the upper bytes of the words are passed in.
module identify_check #(
    parameter int HI_W = 8
) (
    input  logic            udma_ok,
    input  logic            dma_ok,
    input  logic [HI_W-1:0] udma_hi,
    input  logic [HI_W-1:0] mw_hi,
    input  logic [HI_W-1:0] sw_hi,
    output logic            bad
);
    // Which pair is compared depends on the highest valid flag present.
    always_comb begin
        if (udma_ok)
            bad = (udma_hi != '0) && (mw_hi != '0);
        else if (dma_ok)
            bad = (mw_hi != '0) && (sw_hi != '0);
        else
            bad = 1'b0;
    end
endmodule

// File: rtl/mode_priority_pick.sv
`timescale 1ns/1ps
// Module: picks the first eligible family with a non-empty mask, forms its
// code from the highest mask bit and limits it to the request. Assumes
// family index 0 has the highest priority.
module mode_priority_pick
    import xfer_mode_pkg::*;
(
    input  logic [NFAM-1:0][FAM_W-1:0] fam_mask,
    input  mode_t                      req_mode,
    input  logic                       block,
    output mode_t                      sel
);
    localparam int FAM_IW = $clog2(FAM_W);

    logic [NFAM-1:0]             found, eligible;
    logic [NFAM-1:0][FAM_IW-1:0] idx;
    logic [NFAM-1:0][MODE_W-1:0] code;
    mode_t                       chosen;

    for (genvar f = 0; f < NFAM; f++) begin : g_fam
        msb_index #(.W(FAM_W), .IW(FAM_IW)) i_msb (
            .vec   (fam_mask[f]),
            .found (found[f]),
            .idx   (idx[f])
        );
        assign eligible[f] = (req_mode >= fam_base(f));
        assign code[f]     = fam_base(f) + mode_t'(idx[f]);
    end

    // Walk from lowest priority up so the highest-priority hit wins.
    always_comb begin
        chosen = MODE_NONE;
        for (int f = NFAM - 1; f >= 0; f--) begin
            if (eligible[f] && found[f]) chosen = code[f];
        end
    end

    // Apply the device-type gate and the request ceiling.
    always_comb begin
        if (block)
            sel = MODE_NONE;
        else if (chosen < req_mode)
            sel = chosen;
        else
            sel = req_mode;
    end
endmodule

// File: rtl/xfer_mode_select.sv
`timescale 1ns/1ps
// Module: top of the DMA transfer mode selector. It computes the mode
// combinationally from the present inputs and registers the result on a
// strobe. Assumes the inputs are steady in the cycle the strobe is high.
module xfer_mode_select
    import xfer_mode_pkg::*;
#(
    parameter int ID_W     = 16,
    parameter int UDMA_W   = 8,
    parameter int MW_W     = 3,
    parameter int SW_W     = 3,
    parameter int LEG_W    = 8,
    parameter int CAP_KEEP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_mode,
    input  logic [ID_W-1:0]   id_valid_word,
    input  logic [ID_W-1:0]   id_udma_word,
    input  logic [ID_W-1:0]   id_mw_word,
    input  logic [ID_W-1:0]   id_sw_word,
    input  logic [LEG_W-1:0]  legacy_dma_mode,
    input  logic [UDMA_W-1:0] host_udma_mask,
    input  logic [MW_W-1:0]   host_mw_mask,
    input  logic [SW_W-1:0]   host_sw_mask,
    input  logic              cable_80w,
    input  logic              is_disk,
    input  logic              host_no_atapi_dma,
    output logic [7:0]        sel_mode,
    output logic              id_error,
    output logic              done
);
    localparam int HI_W           = ID_W / 2;
    localparam int VALID_UDMA_BIT = 2;
    localparam int VALID_DMA_BIT  = 1;

    logic                       udma_ok, dma_ok, block, bad_id;
    logic [NFAM-1:0][FAM_W-1:0] fam_mask;
    mode_t                      sel_next;
    logic                       unused_id_bits;

    assign udma_ok = id_valid_word[VALID_UDMA_BIT];
    assign dma_ok  = id_valid_word[VALID_DMA_BIT];
    assign block   = !is_disk && host_no_atapi_dma;
    assign unused_id_bits = ^{id_valid_word, id_udma_word, id_mw_word, id_sw_word};

    family_mask_calc #(
        .UDMA_W(UDMA_W), .MW_W(MW_W), .SW_W(SW_W),
        .LEG_W(LEG_W), .CAP_KEEP(CAP_KEEP)
    ) i_masks (
        .udma_ok     (udma_ok),
        .dma_ok      (dma_ok),
        .udma_bits   (id_udma_word[UDMA_W-1:0]),
        .mw_bits     (id_mw_word[MW_W-1:0]),
        .sw_bits     (id_sw_word[SW_W-1:0]),
        .legacy_mode (legacy_dma_mode),
        .host_udma   (host_udma_mask),
        .host_mw     (host_mw_mask),
        .host_sw     (host_sw_mask),
        .cable_80w   (cable_80w),
        .req_mode    (req_mode),
        .fam_mask    (fam_mask)
    );

    mode_priority_pick i_pick (
        .fam_mask (fam_mask),
        .req_mode (req_mode),
        .block    (block),
        .sel      (sel_next)
    );

    identify_check #(.HI_W(HI_W)) i_idchk (
        .udma_ok (udma_ok),
        .dma_ok  (dma_ok),
        .udma_hi (id_udma_word[ID_W-1:HI_W]),
        .mw_hi   (id_mw_word[ID_W-1:HI_W]),
        .sw_hi   (id_sw_word[ID_W-1:HI_W]),
        .bad     (bad_id)
    );

    // Capture the result on a strobe and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mode <= MODE_NONE;
            id_error <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= req_valid;
            if (req_valid) begin
                sel_mode <= sel_next;
                id_error <= bad_id;
            end
        end
    end
endmodule

// File: rtl/xfer_mode_select_chk.sv
`timescale 1ns/1ps
// Module: property checker for the mode selector, attached by bind.
module xfer_mode_select_chk #(
    parameter int ID_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [7:0]      req_mode,
    input logic [ID_W-1:0] id_valid_word,
    input logic            is_disk,
    input logic            host_no_atapi_dma,
    input logic [7:0]      sel_mode,
    input logic            id_error,
    input logic            done
);
    // R1: done follows the strobe by exactly one cycle
    assert_done_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    assert_no_done_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    // R1: outputs hold between strobes
    assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(sel_mode) && $stable(id_error)));
    // R2: packet device on a host without packet DMA gets no DMA
    assert_atapi_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_disk && host_no_atapi_dma) |=> (sel_mode == 8'h00));
    // R3: result is zero or sits in exactly one family
    assert_code_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((sel_mode == 8'h00) || ($countones(sel_mode[7:4]) == 1)));
    // R5: without the Ultra DMA valid bit no Ultra DMA code appears
    assert_udma_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !id_valid_word[2]) |=> (sel_mode < 8'h40));
    // R8: with no valid bits only single-word codes can appear
    assert_legacy_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !id_valid_word[2] && !id_valid_word[1]) |=> (sel_mode < 8'h20));
    // R9: result never exceeds the request
    assert_request_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (sel_mode <= $past(req_mode)));
    // R10: error needs one of the valid bits
    assert_error_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !id_valid_word[2] && !id_valid_word[1]) |=> !id_error);
endmodule

bind xfer_mode_select xfer_mode_select_chk #(.ID_W(ID_W)) i_chk (.*);

// File: tb/test_xfer_mode_select.sv
`timescale 1ns/1ps
// Directed bench for the DMA transfer mode selector.
module test_xfer_mode_select;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [7:0]  req_mode;
    logic [15:0] id_valid_word, id_udma_word, id_mw_word, id_sw_word;
    logic [7:0]  legacy_dma_mode;
    logic [7:0]  host_udma_mask;
    logic [2:0]  host_mw_mask, host_sw_mask;
    logic        cable_80w, is_disk, host_no_atapi_dma;
    logic [7:0]  sel_mode;
    logic        id_error, done;

    int n_cmp = 0;
    int n_mis = 0;

    always #2 clk = ~clk;

    xfer_mode_select i_xfer_mode_select (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .id_valid_word(id_valid_word), .id_udma_word(id_udma_word),
        .id_mw_word(id_mw_word), .id_sw_word(id_sw_word),
        .legacy_dma_mode(legacy_dma_mode), .host_udma_mask(host_udma_mask),
        .host_mw_mask(host_mw_mask), .host_sw_mask(host_sw_mask),
        .cable_80w(cable_80w), .is_disk(is_disk),
        .host_no_atapi_dma(host_no_atapi_dma),
        .sel_mode(sel_mode), .id_error(id_error), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Full-capability disk on an 80-wire cable asking for Ultra DMA 6.
    task automatic base_setup();
        req_mode          = 8'h46;
        id_valid_word     = 16'h0006;
        id_udma_word      = 16'h003F;
        id_mw_word        = 16'h0007;
        id_sw_word        = 16'h0007;
        legacy_dma_mode   = 8'h00;
        host_udma_mask    = 8'h7F;
        host_mw_mask      = 3'h7;
        host_sw_mask      = 3'h7;
        cable_80w         = 1'b1;
        is_disk           = 1'b1;
        host_no_atapi_dma = 1'b0;
    endtask

    // Strobe with the inputs set now; check the registered result.
    task automatic run_sel(input string req, input logic [7:0] exp_mode,
                           input logic exp_err);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "done", {31'd0, done}, 32'd1);
        check(req, "mode", {24'd0, sel_mode}, {24'd0, exp_mode});
        check(req, "err", {31'd0, id_error}, {31'd0, exp_err});
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "reset mode", {24'd0, sel_mode}, 32'd0);
        check("R1", "reset err", {31'd0, id_error}, 32'd0);
        check("R1", "reset done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_udma_top();
        base_setup();
        run_sel("R4", 8'h45, 1'b0);
        check("R1", "done falls", {31'd0, done}, 32'd0);
    endtask

    task automatic t_hold();
        base_setup();
        run_sel("R1", 8'h45, 1'b0);
        req_mode     = 8'h10;
        id_valid_word = 16'h0004;
        id_udma_word = 16'h0101;
        id_mw_word   = 16'h0101;
        repeat (3) @(negedge clk);
        check("R1", "held mode", {24'd0, sel_mode}, 32'h45);
        check("R1", "held err", {31'd0, id_error}, 32'd0);
        check("R1", "no done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_cable();
        base_setup();
        cable_80w = 1'b0;
        run_sel("R6", 8'h42, 1'b0);
        base_setup();
        cable_80w = 1'b0; id_udma_word = 16'h0080; host_udma_mask = 8'hFF;
        req_mode = 8'h47;
        run_sel("R6", 8'h47, 1'b0);
        base_setup();
        cable_80w = 1'b0; req_mode = 8'h41;
        run_sel("R6", 8'h41, 1'b0);
    endtask

    task automatic t_udma_masks();
        base_setup();
        host_udma_mask = 8'h07;
        run_sel("R5", 8'h42, 1'b0);
        base_setup();
        id_valid_word = 16'h0002; id_mw_word = 16'h0003;
        run_sel("R5", 8'h21, 1'b0);
    endtask

    task automatic t_request_limit();
        base_setup();
        req_mode = 8'h43;
        run_sel("R9", 8'h43, 1'b0);
        base_setup();
        req_mode = 8'h11;
        run_sel("R9", 8'h11, 1'b0);
    endtask

    task automatic t_order();
        base_setup();
        req_mode = 8'h22; id_mw_word = 16'h0003;
        run_sel("R3", 8'h21, 1'b0);
        base_setup();
        req_mode = 8'h0C;
        run_sel("R3", 8'h00, 1'b0);
        base_setup();
        id_udma_word = 16'h0000; id_mw_word = 16'h0000; id_sw_word = 16'h0000;
        run_sel("R3", 8'h00, 1'b0);
    endtask

    task automatic t_mw_sw();
        base_setup();
        id_valid_word = 16'h0002; host_mw_mask = 3'h0;
        run_sel("R7", 8'h12, 1'b0);
        base_setup();
        id_valid_word = 16'h0002; id_mw_word = 16'h0000; id_sw_word = 16'h0002;
        run_sel("R8", 8'h11, 1'b0);
    endtask

    task automatic t_legacy();
        base_setup();
        id_valid_word = 16'h0000; legacy_dma_mode = 8'd1;
        run_sel("R8", 8'h11, 1'b0);
        legacy_dma_mode = 8'd2;
        run_sel("R8", 8'h12, 1'b0);
        host_sw_mask = 3'h3;
        run_sel("R8", 8'h11, 1'b0);
        host_sw_mask = 3'h7; legacy_dma_mode = 8'd3;
        run_sel("R8", 8'h00, 1'b0);
        legacy_dma_mode = 8'd0;
        run_sel("R8", 8'h00, 1'b0);
    endtask

    task automatic t_atapi();
        base_setup();
        is_disk = 1'b0; host_no_atapi_dma = 1'b1;
        run_sel("R2", 8'h00, 1'b0);
        is_disk = 1'b0; host_no_atapi_dma = 1'b0;
        run_sel("R2", 8'h45, 1'b0);
        is_disk = 1'b1; host_no_atapi_dma = 1'b1;
        run_sel("R2", 8'h45, 1'b0);
    endtask

    task automatic t_error();
        base_setup();
        id_valid_word = 16'h0004; id_udma_word = 16'h0101; id_mw_word = 16'h0107;
        run_sel("R10", 8'h40, 1'b1);
        base_setup();
        id_valid_word = 16'h0002; id_mw_word = 16'h0107; id_sw_word = 16'h0107;
        run_sel("R10", 8'h22, 1'b1);
        base_setup();
        id_mw_word = 16'h0107; id_sw_word = 16'h0107;
        run_sel("R10", 8'h45, 1'b0);
        base_setup();
        id_valid_word = 16'h0000; id_udma_word = 16'h0100;
        id_mw_word = 16'h0100; id_sw_word = 16'h0100;
        run_sel("R10", 8'h00, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_mis++;
        $display("FAIL R1 watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        base_setup();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_udma_top();
        t_hold();
        t_cable();
        t_udma_masks();
        t_request_limit();
        t_order();
        t_mw_sw();
        t_legacy();
        t_atapi();
        t_error();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule